// File: doc/BRIEF.md
# Bundle Register File with Queue-Mapped Network Ports

This block is the operand store for a three-slot issue core. Each cycle it takes one bundle of up to seven source reads and three destination writes, and the bundle takes effect as a single unit. The register numbers fall into three groups. Numbers 0 to 55 select stored 64-bit registers. Numbers 56 and 63 always read as zero. Numbers 57 to 62 do not select storage: each one selects one of six inbound message queues, and two of them also select one of two outbound queues.

A read of an inbound-queue number returns the head of that queue. When the bundle commits, the queue gives up exactly one entry, however many slots named it. A write to number 57 or 59 places the value into the outbound queue of the first or second network. When a bundle would read an empty inbound queue or write a full outbound queue, the block raises a stall and the bundle makes no change anywhere. An abort input cancels a bundle in the same way. Each queue connects to its network side through a ready/valid handshake.

Top module: `netq_bundle_regfile`

## Requirements
- R1: Writes to numbers 0 to 55 are stored and read back by any later bundle. Reset clears all of them to zero.
- R2: Numbers 56 and 63 always read as zero, and writes to them change nothing.
- R3: Every source of a bundle reads the state from before that bundle. A slot that reads a register written in the same bundle gets the old value, and the next bundle sees the new one.
- R4: Numbers 57 to 62 read the heads of inbound queues 0 to 5 in that order. A committed bundle removes exactly one entry from each queue it names, and every slot that names the same queue gets the same value.
- R5: A write to 57 enqueues to outbound queue 0 and a write to 59 enqueues to outbound queue 1. Writes to 58, 60, 61 and 62 are ignored. If several slots of one bundle target the same outbound queue or register, the highest-numbered slot wins and only one entry is enqueued.
- R6: The stall output is high exactly when the bundle is valid and an enabled read names an empty inbound queue, or an enabled write targets an outbound queue that holds 4 entries. A stalled bundle makes no register write, no dequeue and no enqueue.
- R7: A valid bundle with the abort input high makes no register write, no dequeue and no enqueue.
- R8: Each queue holds 4 entries in arrival order. An inbound queue drops its ready while it is full. An outbound queue holds valid high while it is not empty.
- R9: Read and write slots whose enable is low cause no stall, no dequeue and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_valid | input | 1 | A bundle is presented this cycle |
| bnd_abort | input | 1 | The bundle raised an exception; commit nothing |
| bnd_stall | output | 1 | The bundle cannot proceed this cycle |
| rd_en | input | NRD | Per-slot source enable |
| rd_addr | input | NRD*6 | Per-slot source register number |
| rd_data | output | NRD*W | Per-slot source value |
| wr_en | input | NWR | Per-slot destination enable |
| wr_addr | input | NWR*6 | Per-slot destination register number |
| wr_data | input | NWR*W | Per-slot destination value |
| nin_valid | input | 6 | Inbound queue push valid |
| nin_data | input | 6*W | Inbound queue push data |
| nin_ready | output | 6 | Inbound queue can accept |
| nout_valid | output | 2 | Outbound queue holds an entry |
| nout_data | output | 2*W | Outbound queue head |
| nout_ready | input | 2 | Network takes the outbound head |

## Verification
The same bundle can read a register or queue and also write a register or queue. The same cycle can also combine a commit with a stall cause or with an abort. The bench provokes this in three ways: it writes a register the bundle also reads; it pairs a read of an empty queue, or a write to a full queue, with an ordinary register write; and it aborts a bundle that both dequeues and enqueues. It judges each case at the ports. It checks the read value during the bundle, the register value in the next cycle, the queue head that remains, and the exact sequence of outbound entries, which a scoreboard compares against the values it expected to be enqueued.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
    localparam int RA_W       = 6;   // register number width
    localparam int N_STORE    = 56;  // numbers 0..55 hold state
    localparam int N_INQ      = 6;   // inbound queues
    localparam int N_OUTQ     = 2;   // outbound queues
    localparam int IN_BASE    = 57;  // first inbound-queue number
    localparam int TX_A       = 57;  // first network send number
    localparam int TX_B       = 59;  // second network send number
endpackage

// File: rtl/nrf_fifo.sv
module nrf_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wp] = push_data;
            s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (pop) begin
            s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head      = s_q.mem[s_q.rp];
    assign not_empty = (s_q.cnt != '0);
    assign full      = (s_q.cnt == CW'(DEPTH));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop))
        else $error("queue pushed while full");
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty)
        else $error("queue popped while empty");
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH))
        else $error("queue count beyond depth");
endmodule

// File: rtl/nrf_regstore.sv
module nrf_regstore
    import nrf_pkg::*;
#(
    parameter int W      = 64,
    parameter int NSTORE = 56,
    parameter int NRD    = 7,
    parameter int NWR    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NWR-1:0]             we,
    input  logic [NWR-1:0][RA_W-1:0]   waddr,
    input  logic [NWR-1:0][W-1:0]      wdata,
    input  logic [NRD-1:0][RA_W-1:0]   raddr,
    output logic [NRD-1:0][W-1:0]      rdata
);
    typedef struct packed {
        logic [NSTORE-1:0][W-1:0] mem;
    } store_st_t;

    store_st_t st_d, st_q;

    // Later slots override earlier ones on a shared destination.
    always_comb begin
        st_d = st_q;
        for (int w = 0; w < NWR; w++) begin
            if (we[w] && (waddr[w] < RA_W'(NSTORE)))
                st_d.mem[waddr[w]] = wdata[w];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Reads see only state from before the current edge.
    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            rdata[r] = (raddr[r] < RA_W'(NSTORE)) ? st_q.mem[raddr[r]] : '0;
        end
    end

    assert_last_slot_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we[NWR-1] && (waddr[NWR-1] < RA_W'(NSTORE)))
        |=> st_q.mem[$past(waddr[NWR-1])] == $past(wdata[NWR-1]))
        else $error("stored value differs from committed write");
endmodule

// File: rtl/netq_bundle_regfile.sv
module netq_bundle_regfile
    import nrf_pkg::*;
#(
    parameter int W      = 64,
    parameter int NRD    = 7,
    parameter int NWR    = 3,
    parameter int QDEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bnd_valid,
    input  logic                       bnd_abort,
    output logic                       bnd_stall,
    input  logic [NRD-1:0]             rd_en,
    input  logic [NRD-1:0][RA_W-1:0]   rd_addr,
    output logic [NRD-1:0][W-1:0]      rd_data,
    input  logic [NWR-1:0]             wr_en,
    input  logic [NWR-1:0][RA_W-1:0]   wr_addr,
    input  logic [NWR-1:0][W-1:0]      wr_data,
    input  logic [N_INQ-1:0]           nin_valid,
    input  logic [N_INQ-1:0][W-1:0]    nin_data,
    output logic [N_INQ-1:0]           nin_ready,
    output logic [N_OUTQ-1:0]          nout_valid,
    output logic [N_OUTQ-1:0][W-1:0]   nout_data,
    input  logic [N_OUTQ-1:0]          nout_ready
);
    logic [N_INQ-1:0]           inq_ne, inq_full, inq_hit, inq_pop;
    logic [N_INQ-1:0][W-1:0]    inq_head;
    logic [N_OUTQ-1:0]          outq_ne, outq_full, outq_hit, outq_push;
    logic [N_OUTQ-1:0][W-1:0]   outq_wdata;
    logic [NRD-1:0][W-1:0]      store_rdata;
    logic [NWR-1:0]             reg_we;
    logic                       starve, blocked, commit;

    // Hazard detection and commit decision.
    always_comb begin
        inq_hit    = '0;
        outq_hit   = '0;
        outq_wdata = '0;
        for (int r = 0; r < NRD; r++) begin
            for (int q = 0; q < N_INQ; q++) begin
                if (rd_en[r] && (rd_addr[r] == RA_W'(IN_BASE + q)))
                    inq_hit[q] = 1'b1;
            end
        end
        for (int w = 0; w < NWR; w++) begin
            if (wr_en[w] && (wr_addr[w] == RA_W'(TX_A))) begin
                outq_hit[0]   = 1'b1;
                outq_wdata[0] = wr_data[w];
            end
            if (wr_en[w] && (wr_addr[w] == RA_W'(TX_B))) begin
                outq_hit[1]   = 1'b1;
                outq_wdata[1] = wr_data[w];
            end
        end
        starve    = |(inq_hit & ~inq_ne);
        blocked   = |(outq_hit & outq_full);
        bnd_stall = bnd_valid & (starve | blocked);
        commit    = bnd_valid & ~bnd_stall & ~bnd_abort;
        inq_pop   = inq_hit & {N_INQ{commit}};
        outq_push = outq_hit & {N_OUTQ{commit}};
        reg_we    = wr_en & {NWR{commit}};
    end

    // Source operand selection: queue heads override storage.
    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            rd_data[r] = store_rdata[r];
            for (int q = 0; q < N_INQ; q++) begin
                if (rd_addr[r] == RA_W'(IN_BASE + q))
                    rd_data[r] = inq_ne[q] ? inq_head[q] : '0;
            end
        end
    end

    nrf_regstore #(.W(W), .NSTORE(N_STORE), .NRD(NRD), .NWR(NWR)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (store_rdata)
    );

    for (genvar q = 0; q < N_INQ; q++) begin : g_inq
        nrf_fifo #(.W(W), .DEPTH(QDEPTH)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (nin_valid[q] & ~inq_full[q]),
            .push_data (nin_data[q]),
            .pop       (inq_pop[q]),
            .head      (inq_head[q]),
            .not_empty (inq_ne[q]),
            .full      (inq_full[q])
        );
        assign nin_ready[q] = ~inq_full[q];
    end

    for (genvar n = 0; n < N_OUTQ; n++) begin : g_outq
        nrf_fifo #(.W(W), .DEPTH(QDEPTH)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (outq_push[n]),
            .push_data (outq_wdata[n]),
            .pop       (nout_ready[n] & outq_ne[n]),
            .head      (nout_data[n]),
            .not_empty (outq_ne[n]),
            .full      (outq_full[n])
        );
        assign nout_valid[n] = outq_ne[n];
    end

    assert_stall_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_stall |-> (inq_pop == '0 && outq_push == '0 && reg_we == '0))
        else $error("stalled bundle committed");
    assert_idle_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_valid |-> !bnd_stall)
        else $error("stall without bundle");
    assert_abort_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_abort |-> (inq_pop == '0 && outq_push == '0 && reg_we == '0))
        else $error("aborted bundle committed");

    for (genvar r = 0; r < NRD; r++) begin : g_zchk
        assert_zero_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr[r] == RA_W'(63) || rd_addr[r] == RA_W'(56)) |-> rd_data[r] == '0)
            else $error("zero register read nonzero");
    end
endmodule

// File: tb/netq_bundle_regfile_tb.sv
module netq_bundle_regfile_tb;
    localparam int W = 64, NRD = 7, NWR = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic                 rst_n;
    logic                 bnd_valid, bnd_abort, bnd_stall;
    logic [NRD-1:0]       rd_en;
    logic [NRD-1:0][5:0]  rd_addr;
    logic [NRD-1:0][W-1:0] rd_data;
    logic [NWR-1:0]       wr_en;
    logic [NWR-1:0][5:0]  wr_addr;
    logic [NWR-1:0][W-1:0] wr_data;
    logic [5:0]           nin_valid, nin_ready;
    logic [5:0][W-1:0]    nin_data;
    logic [1:0]           nout_valid, nout_ready;
    logic [1:0][W-1:0]    nout_data;

    int checks = 0, errors = 0;
    logic [W-1:0] expq0[$], expq1[$];

    netq_bundle_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_abort(bnd_abort),
        .bnd_stall(bnd_stall), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .nin_valid(nin_valid), .nin_data(nin_data), .nin_ready(nin_ready),
        .nout_valid(nout_valid), .nout_data(nout_data), .nout_ready(nout_ready)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear();
        bnd_valid = 0; bnd_abort = 0;
        rd_en = '0; rd_addr = '0; wr_en = '0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic rd(int s, int a);
        rd_en[s] = 1'b1; rd_addr[s] = 6'(a);
    endtask

    task automatic wr(int s, int a, logic [W-1:0] d);
        wr_en[s] = 1'b1; wr_addr[s] = 6'(a); wr_data[s] = d;
    endtask

    task automatic go();
        @(posedge clk); @(negedge clk); clear();
    endtask

    task automatic inject(int q, logic [W-1:0] d);
        nin_valid[q] = 1'b1; nin_data[q] = d;
        @(posedge clk); @(negedge clk);
        nin_valid[q] = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Scoreboard monitor: judges each outbound handshake before its edge.
    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n) begin
                if (nout_valid[0] && nout_ready[0]) begin
                    if (expq0.size() == 0) check("R5 unexpected q0 entry", nout_data[0], '0);
                    else check("R5 q0 order", nout_data[0], expq0.pop_front());
                end
                if (nout_valid[1] && nout_ready[1]) begin
                    if (expq1.size() == 0) check("R5 unexpected q1 entry", nout_data[1], '0);
                    else check("R5 q1 order", nout_data[1], expq1.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 0; nin_valid = '0; nin_data = '0; nout_ready = '0;
        clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R8 reset ready", 64'(nin_ready), 64'h3f);
        check("R8 reset out valid", 64'(nout_valid), 0);
        check("R6 idle no stall", 64'(bnd_stall), 0);
        rd(0, 5); #1;
        check("R1 reset value", rd_data[0], 0);
        @(negedge clk); clear();

        // R1: store and read back
        bnd_valid = 1; wr(0, 5, 64'hA5A5); wr(1, 55, 64'hBEEF); wr(2, 54, 64'h5151);
        go();
        rd(0, 5); rd(1, 55); rd(2, 54); #1;
        check("R1 r5", rd_data[0], 64'hA5A5);
        check("R1 r55", rd_data[1], 64'hBEEF);
        check("R1 r54", rd_data[2], 64'h5151);
        @(negedge clk); clear();

        // R3: read-before-write within one bundle
        bnd_valid = 1; rd(0, 5); wr(0, 5, 64'hC0C0); #1;
        check("R3 old value in bundle", rd_data[0], 64'hA5A5);
        go();
        rd(0, 5); #1;
        check("R3 new value next bundle", rd_data[0], 64'hC0C0);
        @(negedge clk); clear();

        // R2: zero numbers
        bnd_valid = 1; wr(0, 56, 64'h1111); wr(1, 63, 64'h2222);
        go();
        rd(0, 56); rd(1, 63); #1;
        check("R2 reg56", rd_data[0], 0);
        check("R2 reg63", rd_data[1], 0);
        @(negedge clk); clear();

        // R6: empty inbound read stalls, no write
        bnd_valid = 1; rd(0, 57); wr(0, 7, 64'h7777); #1;
        check("R6 stall on empty", 64'(bnd_stall), 1);
        go();
        rd(0, 7); #1;
        check("R6 no write while stalled", rd_data[0], 0);
        @(negedge clk); clear();

        // R9: disabled read of empty queue has no effect
        bnd_valid = 1; rd_addr[1] = 6'd60; wr(0, 7, 64'h7777); #1;
        check("R9 disabled read no stall", 64'(bnd_stall), 0);
        go();
        rd(0, 7); #1;
        check("R9 write commits", rd_data[0], 64'h7777);
        @(negedge clk); clear();

        // R4: single dequeue shared by all readers
        inject(0, 64'hAAA1);
        inject(0, 64'hAAA2);
        bnd_valid = 1; rd(0, 57); rd(1, 57); rd(2, 57); #1;
        check("R4 slot0", rd_data[0], 64'hAAA1);
        check("R4 slot1", rd_data[1], 64'hAAA1);
        check("R4 slot2", rd_data[2], 64'hAAA1);
        go();
        rd(0, 57); #1;
        check("R4 one entry removed", rd_data[0], 64'hAAA2);
        @(negedge clk); clear();

        // R7: abort cancels dequeue, enqueue and write
        bnd_valid = 1; bnd_abort = 1; rd(0, 57); wr(0, 8, 64'h8888); wr(1, 57, 64'h9999);
        go();
        rd(0, 57); rd(1, 8); #1;
        check("R7 queue head kept", rd_data[0], 64'hAAA2);
        check("R7 no reg write", rd_data[1], 0);
        check("R7 no enqueue", 64'(nout_valid), 0);
        @(negedge clk); clear();
        bnd_valid = 1; rd(0, 57);
        go();

        // R5: outbound mapping, last slot wins, ignored numbers
        bnd_valid = 1; wr(0, 57, 64'hD1); wr(2, 57, 64'hD2); wr(1, 59, 64'hE1);
        expq0.push_back(64'hD2); expq1.push_back(64'hE1);
        go();
        check("R5 both outbound valid", 64'(nout_valid), 2'b11);
        bnd_valid = 1; wr(0, 60, 64'hBAD0); wr(1, 58, 64'hBAD1); wr(2, 62, 64'hBAD2);
        go();
        for (int i = 0; i < 3; i++) begin
            bnd_valid = 1; wr(0, 57, 64'hF0 + 64'(i));
            expq0.push_back(64'hF0 + 64'(i));
            go();
        end
        bnd_valid = 1; wr(0, 57, 64'h6666); wr(1, 9, 64'h9090); #1;
        check("R6 stall on full outbound", 64'(bnd_stall), 1);
        go();
        rd(0, 9); #1;
        check("R6 no write when full", rd_data[0], 0);
        @(negedge clk); clear();
        nout_ready = 2'b11;
        repeat (8) @(negedge clk);
        check("R5 q0 drained", 64'(expq0.size()), 0);
        check("R5 q1 drained", 64'(expq1.size()), 0);
        check("R5 ignored numbers", 64'(nout_valid), 0);

        // R8: inbound depth and order
        for (int i = 0; i < 4; i++) inject(1, 64'h100 + 64'(i));
        #1;
        check("R8 full drops ready", 64'(nin_ready[1]), 0);
        @(negedge clk);
        inject(1, 64'h1FF);
        for (int i = 0; i < 4; i++) begin
            bnd_valid = 1; rd(0, 58); #1;
            check("R8 inbound order", rd_data[0], 64'h100 + 64'(i));
            go();
        end
        bnd_valid = 1; rd(0, 58); #1;
        check("R8 overflow entry dropped", 64'(bnd_stall), 1);
        @(negedge clk); clear();

        finish_run();
    end
endmodule